// File: doc/BRIEF.md
# Variable Sample-Rate UART Baud Generator

This block turns a peripheral clock into the timing ticks that a high-speed UART needs. The clock first passes through a prescaler that divides by a power of four times two. A divisor then divides the prescaled clock by a programmable count. Each result is one oversampling tick. A sample counter groups the oversampling ticks into bit periods. It marks each bit boundary and gives the receiver a strobe at the middle sample of each bit.

Software sets the block up through three small registers. The mode register holds the prescale select. The bit-rate register holds the divisor. The sample-rate register holds a sample-count field and a bit that enables it. When that bit is clear, the block uses a fixed sixteen samples per bit. Any write to one of these registers restarts all counters from a fresh bit start. Software should allow one bit period after reprogramming before it starts a transfer.

Top module: `vsr_baud_gen`

## Requirements
- R1: The mode register at address 0x00 holds the prescale select c in bits [1:0]. The prescaler divides the input clock by 2^(2c+1), which gives 2, 8, 32 or 128.
- R2: The bit-rate register at address 0x04 holds N (0 to 255) in bits [7:0]. The divisor divides the prescaled clock by N+1.
- R3: `os_tick` is high for exactly one cycle in every 2^(2c+1)·(N+1) clocks. Counting from a restart at cycle 0, it is high in the cycle where (t+1) is a multiple of that period.
- R4: The sample-rate register at address 0x40 holds an enable in bit 15 and (samples-1) in bits [4:0]. With the enable set, a bit has that many samples. With the enable clear, a bit has 16 samples.
- R5: With the enable set, a field value below 7 is treated as 7, which gives 8 samples per bit. The range is 8 to 32 samples per bit.
- R6: `bit_tick` is high together with the `os_tick` of the last sample of each bit, at sample index S-1. It therefore repeats every S·2^(2c+1)·(N+1) clocks.
- R7: `mid_tick` is high together with the `os_tick` of sample index floor(S/2), counted from 0 at the start of the bit.
- R8: A write to any of the three configuration registers resets all counters. The first `os_tick` under the new setting comes one full period after the write.
- R9: A read returns the last written value of the implemented fields. Unimplemented bits read as zero: mode reads bits [1:0], bit-rate reads bits [7:0], sample-rate reads bits 15 and [4:0].
- R10: A write to any other address changes no setting and does not restart the counters. A read from any other address returns zero.
- R11: After reset, c is 0, N is 255 and the sample enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (7) | Register byte address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| os_tick | output | 1 | Oversampling tick |
| bit_tick | output | 1 | Bit-boundary tick, on the last sample of a bit |
| mid_tick | output | 1 | Middle-sample strobe for the receiver |

## Verification
The bench compares the three ticks with a reference model on every clock. It covers each prescale select, divisor values 0, small values and 255, and sample counts of 8, 9 (odd), 16 (default) and 32. A design that takes the middle index of an odd sample count as a ceiling would strobe one sample late. A design that uses the raw sample field without clamping it would produce 4-sample bits. A design that ignores the enable bit would break the default 16-sample behaviour. Writes in the middle of a bit check that the counters restart, and a write to an unused address checks that timing goes on undisturbed. A design that decodes too few address bits would let that write change a setting.

// File: rtl/vsr_baud_pkg.sv
`timescale 1ns/1ps
package vsr_baud_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned PRE_W  = 7;
  localparam int unsigned DIV_W  = 8;
  localparam int unsigned SMP_W  = 5;

  localparam logic [6:0] ADDR_MODE = 7'h00;
  localparam logic [6:0] ADDR_RATE = 7'h04;
  localparam logic [6:0] ADDR_SMPL = 7'h40;

  localparam logic [SMP_W-1:0] SMP_MIN_LAST   = 5'd7;
  localparam logic [SMP_W-1:0] SMP_FIXED_LAST = 5'd15;

  // terminal count of the prescaler: 2^(2c+1) - 1
  function automatic logic [PRE_W-1:0] presc_last(input logic [1:0] c);
    logic [PRE_W:0] len;
    len = (PRE_W+1)'(2) << (2 * c);
    return PRE_W'(len - 1'b1);
  endfunction

  // terminal sample index (samples - 1)
  function automatic logic [SMP_W-1:0] smp_last(input logic en,
                                                input logic [SMP_W-1:0] fld);
    if (!en) return SMP_FIXED_LAST;
    if (fld < SMP_MIN_LAST) return SMP_MIN_LAST;
    return fld;
  endfunction

  // middle sample index: floor(samples / 2)
  function automatic logic [SMP_W-1:0] smp_mid(input logic [SMP_W-1:0] last);
    logic [SMP_W:0] cnt;
    cnt = {1'b0, last} + 1'b1;
    return SMP_W'(cnt >> 1);
  endfunction
endpackage

// File: rtl/vsr_tick_counter.sv
`timescale 1ns/1ps
module vsr_tick_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] last,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = en && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/vsr_cfg_regs.sv
`timescale 1ns/1ps
module vsr_cfg_regs
  import vsr_baud_pkg::*;
#(
  parameter int unsigned AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        cks,
  output logic [DIV_W-1:0]  brr,
  output logic              smp_en,
  output logic [SMP_W-1:0]  smp_fld,
  output logic              cfg_wr
);
  logic hit_mode, hit_rate, hit_smpl;
  logic unused_wbits;

  assign hit_mode = (addr == AW'(ADDR_MODE));
  assign hit_rate = (addr == AW'(ADDR_RATE));
  assign hit_smpl = (addr == AW'(ADDR_SMPL));
  assign cfg_wr   = wr_en && (hit_mode || hit_rate || hit_smpl);
  assign unused_wbits = ^wdata[14:8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cks     <= 2'd0;
      brr     <= '1;
      smp_en  <= 1'b0;
      smp_fld <= '0;
    end else if (wr_en) begin
      if (hit_mode) cks <= wdata[1:0];
      if (hit_rate) brr <= wdata[DIV_W-1:0];
      if (hit_smpl) begin
        smp_en  <= wdata[15];
        smp_fld <= wdata[SMP_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_mode) rdata[1:0] = cks;
    if (hit_rate) rdata[DIV_W-1:0] = brr;
    if (hit_smpl) begin
      rdata[15] = smp_en;
      rdata[SMP_W-1:0] = smp_fld;
    end
  end
endmodule

// File: rtl/vsr_baud_gen.sv
`timescale 1ns/1ps
module vsr_baud_gen
  import vsr_baud_pkg::*;
#(
  parameter int unsigned AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              os_tick,
  output logic              bit_tick,
  output logic              mid_tick
);
  logic [1:0]       cks;
  logic [DIV_W-1:0] brr;
  logic             smp_en;
  logic [SMP_W-1:0] smp_fld;
  logic             cfg_wr;

  logic [PRE_W-1:0] pre_last;
  logic [SMP_W-1:0] s_last, s_mid;
  logic             pre_tick;
  logic [PRE_W-1:0] pre_cnt_unused;
  logic [DIV_W-1:0] div_cnt_unused;
  logic [SMP_W-1:0] smp_cnt;

  vsr_cfg_regs #(.AW(AW)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cks(cks), .brr(brr), .smp_en(smp_en),
    .smp_fld(smp_fld), .cfg_wr(cfg_wr)
  );

  assign pre_last = presc_last(cks);
  assign s_last   = smp_last(smp_en, smp_fld);
  assign s_mid    = smp_mid(s_last);

  vsr_tick_counter #(.W(PRE_W)) i_pre (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .en(1'b1),
    .last(pre_last), .cnt(pre_cnt_unused), .wrap(pre_tick)
  );

  vsr_tick_counter #(.W(DIV_W)) i_div (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .en(pre_tick),
    .last(brr), .cnt(div_cnt_unused), .wrap(os_tick)
  );

  vsr_tick_counter #(.W(SMP_W)) i_smp (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .en(os_tick),
    .last(s_last), .cnt(smp_cnt), .wrap(bit_tick)
  );

  assign mid_tick = os_tick && (smp_cnt == s_mid);
endmodule

// File: rtl/vsr_baud_gen_chk.sv
`timescale 1ns/1ps
module vsr_baud_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic        pre_tick,
  input logic [6:0]  addr,
  input logic [15:0] rdata,
  input logic        os_tick,
  input logic        bit_tick,
  input logic        mid_tick
);
  logic [5:0] os_since_bit;

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_wr || bit_tick) os_since_bit <= '0;
    else if (os_tick) os_since_bit <= os_since_bit + 1'b1;
  end

  p_bit_on_os_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);
  p_mid_on_os_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mid_tick |-> (os_tick && !bit_tick));
  p_os_needs_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |-> pre_tick);
  p_no_back_to_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |=> !os_tick);
  p_restart_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (!os_tick && !pre_tick));
  p_bit_within_32_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && os_since_bit == 6'd31) |-> bit_tick);
  p_smpl_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 7'h40) |-> (rdata[14:5] == 10'd0));
endmodule

bind vsr_baud_gen vsr_baud_gen_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .pre_tick(pre_tick),
  .addr(addr), .rdata(rdata), .os_tick(os_tick), .bit_tick(bit_tick),
  .mid_tick(mid_tick)
);

// File: tb/test_vsr_baud_gen.sv
`timescale 1ns/1ps
module test_vsr_baud_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        os_tick, bit_tick, mid_tick;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit live = 0;

  // reference model state
  int m_c = 0, m_n = 255, m_en = 0, m_f = 0;
  longint m_t = 0;

  always #5 clk = ~clk;

  vsr_baud_gen i_vsr_baud_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .os_tick(os_tick), .bit_tick(bit_tick), .mid_tick(mid_tick)
  );

  function automatic int samples_now();
    if (m_en == 0) return 16;
    return (m_f < 7) ? 8 : m_f + 1;
  endfunction

  // model advances at each rising edge, seeing the same inputs as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      m_c = 0; m_n = 255; m_en = 0; m_f = 0; m_t = 0;
    end else if (wr_en && (addr == 7'h00 || addr == 7'h04 || addr == 7'h40)) begin
      if (addr == 7'h00) m_c = wdata[1:0];
      if (addr == 7'h04) m_n = wdata[7:0];
      if (addr == 7'h40) begin m_en = wdata[15]; m_f = wdata[4:0]; end
      m_t = 0;
    end else begin
      m_t = m_t + 1;
    end
  end

  // compare in the middle of every cycle (R1-related tags stated per check below)
  always @(negedge clk) begin
    if (live) begin
      longint per, k;
      int s, idx;
      bit e_os, e_bit, e_mid;
      per = longint'(1 << (2 * m_c + 1)) * (m_n + 1);
      s = samples_now();
      e_os = ((m_t + 1) % per) == 0;
      k = (m_t + 1) / per - 1;
      idx = (k < 0) ? 0 : int'(k % s);
      e_bit = e_os && (idx == s - 1);
      e_mid = e_os && (idx == s / 2);
      total++;
      if (os_tick !== e_os) begin
        bad++;
        $display("FAIL R3 (R1 R2) os_tick t=%0d got %b exp %b", m_t, os_tick, e_os);
      end
      total++;
      if (bit_tick !== e_bit) begin
        bad++;
        $display("FAIL R6 (R4 R5) bit_tick t=%0d got %b exp %b", m_t, bit_tick, e_bit);
      end
      total++;
      if (mid_tick !== e_mid) begin
        bad++;
        $display("FAIL R7 mid_tick t=%0d got %b exp %b", m_t, mid_tick, e_mid);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr_en = 1'b0; addr = 7'h7f;
  endtask

  task automatic rd_check(input logic [6:0] a, input logic [15:0] exp,
                          input string req);
    @(negedge clk); #1;
    addr = a;
    #1;
    total++;
    if (rdata !== exp) begin
      bad++;
      $display("FAIL %s read addr %h got %h exp %h", req, a, rdata, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    live = 1;
    // R11: reset values read back
    rd_check(7'h00, 16'h0000, "R11");
    rd_check(7'h04, 16'h00ff, "R11");
    rd_check(7'h40, 16'h0000, "R11");
    // R11 R4: default timing, 512-cycle samples, 16 per bit
    run(8800);
    // R1 R5: c=0 N=0, enable with 8 samples
    wr(7'h00, 16'h0000);
    wr(7'h04, 16'h0000);
    wr(7'h40, 16'h8007);
    run(200);
    // R5: field below 7 clamps to 8 samples
    wr(7'h40, 16'h8003);
    run(200);
    // R1 R4: c=1 N=2, 32 samples
    wr(7'h00, 16'h0001);
    wr(7'h04, 16'h0002);
    wr(7'h40, 16'h801f);
    run(2000);
    // R4: enable clear gives 16 samples, c=2 N=0
    wr(7'h00, 16'h0002);
    wr(7'h04, 16'h0000);
    wr(7'h40, 16'h001f);
    run(1200);
    // R7: odd sample count 9, c=3 N=1
    wr(7'h00, 16'h0003);
    wr(7'h04, 16'h0001);
    wr(7'h40, 16'h8008);
    run(5000);
    // R8: restart in mid-bit with a new divisor
    wr(7'h04, 16'h0000);
    run(300);
    wr(7'h00, 16'h0000);
    wr(7'h40, 16'h8009);
    run(150);
    wr(7'h04, 16'h0001);
    run(500);
    // R10: write to unused address leaves timing and settings alone
    wr(7'h20, 16'hffff);
    run(400);
    rd_check(7'h20, 16'h0000, "R10");
    rd_check(7'h04, 16'h0001, "R10");
    // R9: read masks
    wr(7'h00, 16'hfffe);
    rd_check(7'h00, 16'h0002, "R9");
    wr(7'h04, 16'h12ab);
    rd_check(7'h04, 16'h00ab, "R9");
    wr(7'h40, 16'hffff);
    rd_check(7'h40, 16'h801f, "R9");
    // R2: largest settings, no tick before its long period
    wr(7'h00, 16'h0003);
    wr(7'h04, 16'h00ff);
    run(3000);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule